// File: doc/BRIEF.md
# ISA I/O Bus Bridge

This bridge connects a 32-bit CPU I/O window to an 8/16-bit ISA-style peripheral bus. The CPU presents one request at a time: a byte offset into the window, a transfer size, a read/write flag and write data. The bridge decodes the offset, drives one or two timed ISA strobe cycles, and answers on the same handshake with read data or an error flag.

Two address schemes share the window. Three serial/parallel port groups use a 4-byte stride. Every other port uses a 2-byte stride. In that 2-byte region a byte's lane chooses between the even port and the odd port on the high lane. A word-sized access to the slot one below an odd port is a redirect access. It reaches that odd port with the data on the low lane, so 8-bit devices can use odd ports. A 32-bit read to a port that is a multiple of 4 becomes two 16-bit cycles.

Request handshake rules: the CPU raises `req_valid` and keeps every `req_*` field stable until it sees `req_ready`. `req_ready` is high for exactly one clock, and a transfer completes on a clock where both are high. The bridge takes a new request only from the idle state, so a request raised in the clock after the pulse is accepted one clock later.

Top module: `isa_io_bridge`

## Requirements
- R1: While reset is held and in the first clock after it, `req_ready`, `rsp_err`, `isa_ior`, `isa_iow` and `isa_bhe` are low.
- R2: `req_ready` is a one-clock pulse. Counting rising edges from the clock at which `req_valid` is first seen, it comes STB_CLKS+1 edges later for a single ISA cycle, 2*STB_CLKS+2 edges later for a split read, and 1 edge later for an error.
- R3: The grouped region is every offset whose bits [11:5] equal 0x7F, 0x6F or 0x5F, and it takes priority over the 2-byte region. In it, a byte (`req_size`=0) or halfword (`req_size`=1) with offset bits [1:0]=0 drives ISA address offset>>2 with `isa_bhe` low. A byte uses lane bits [7:0] and a halfword uses all 16 bits.
- R4: In the 2-byte region, a byte with offset bits [1:0]=00 drives address (offset>>2)*2 with `isa_bhe` low. Data sits on bus bits [7:0] and is returned zero-extended in `rsp_rdata[7:0]`.
- R5: In the 2-byte region, a byte with offset bits [1:0]=01 drives address (offset>>2)*2+1 with `isa_bhe` high. Write data `req_wdata[7:0]` appears on bus bits [15:8], and a read returns bus bits [15:8] in `rsp_rdata[7:0]`.
- R6: In the 2-byte region, a halfword with offset bits [1:0]=00 drives address (offset>>2)*2 with `isa_bhe` high and carries 16 bits.
- R7: In the 2-byte region, a word (`req_size`=2) with offset bits [2:0]=100 is a redirect access. It drives address (offset>>2)*2+1 with `isa_bhe` low, and its data is on bus bits [7:0].
- R8: In the 2-byte region, a word read with offset bits [2:0]=000 runs two cycles, at addresses (offset>>2)*2 and (offset>>2)*2+2, both with `isa_bhe` high, with exactly one strobe-free clock between them. The result is {second, first}.
- R9: The following get `rsp_err` high with `rsp_rdata`=0 and no ISA strobe: `req_size`=3; any word in the grouped region; any grouped access with offset bits [1:0]≠0; any 2-byte-region access with offset bit 1 set; a halfword or word there with offset bit 0 set; and a word write with offset bits [2:0]=000.
- R10: Each ISA cycle holds exactly one strobe for STB_CLKS clocks. `isa_ior` is used for reads and `isa_iow` for writes, and the two are never high together. `isa_dout` is zero whenever `isa_iow` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | One-clock completion pulse |
| req_offset | input | OFS_W | Byte offset inside the I/O window |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 16 | Write data; no legal write carries more than 16 bits |
| rsp_err | output | 1 | Error flag, valid with `req_ready` |
| rsp_rdata | output | 32 | Read data, valid with `req_ready`, otherwise zero |
| isa_addr | output | OFS_W-1 | ISA port address, bit 0 is A0 |
| isa_bhe | output | 1 | High-byte enable, active high during strobes |
| isa_ior | output | 1 | I/O read strobe, active high |
| isa_iow | output | 1 | I/O write strobe, active high |
| isa_dout | output | 16 | Bus write data |
| isa_din | input | 16 | Bus read data, sampled in the last strobe clock |

## Verification
A wrong decode shows on the first strobe clock, as a wrong `isa_addr` or `isa_bhe` within two clocks of acceptance. A lost or stale second-half flag in the sequencer shows as a missing or third strobe run, or as a wrong second address, before the ready pulse. A wrong sampling point or a wrong lane choice shows only in `rsp_rdata` at the ready pulse. Every offset of the window is therefore swept at every size and direction, and address, enable, strobe count, span, latency and returned data are all compared against values the bench computes.

// File: rtl/isa_bridge_pkg.sv
package isa_bridge_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    LN_LO8 = 2'd0,
    LN_HI8 = 2'd1,
    LN_W16 = 2'd2
  } lane_e;

  typedef struct packed {
    logic  err;
    logic  split;
    logic  bhe;
    lane_e lane;
  } isa_plan_t;

  // first port of each 4-byte-stride group (eight ports per group)
  localparam int SIO_GROUPS = 3;
  localparam logic [SIO_GROUPS-1:0][9:0] SIO_PORT_BASE = {10'h3F8, 10'h378, 10'h2F8};

endpackage

// File: rtl/isa_addr_decode.sv
module isa_addr_decode
  import isa_bridge_pkg::*;
#(
  parameter int OFS_W  = 12,
  parameter int ADDR_W = OFS_W - 1
) (
  input  logic [OFS_W-1:0]  offset,
  input  logic [1:0]        size,
  input  logic              wr,
  output isa_plan_t         plan,
  output logic [ADDR_W-1:0] addr
);
  localparam int GW = OFS_W - 5;

  logic [SIO_GROUPS-1:0] grp_hit;
  logic                  sio;
  logic [ADDR_W-1:0]     base2;
  logic [ADDR_W-1:0]     sio_addr;

  for (genvar gi = 0; gi < SIO_GROUPS; gi++) begin : g_grp
    assign grp_hit[gi] = (offset[OFS_W-1:5] == GW'(SIO_PORT_BASE[gi] >> 3));
  end

  assign sio      = |grp_hit;
  assign base2    = ADDR_W'({offset[OFS_W-1:2], 1'b0});
  assign sio_addr = ADDR_W'(offset[OFS_W-1:2]);

  always_comb begin
    plan = '{err: 1'b0, split: 1'b0, bhe: 1'b0, lane: LN_LO8};
    addr = base2;
    if (sio) begin
      addr      = sio_addr;
      plan.lane = (xfer_size_e'(size) == SZ_BYTE) ? LN_LO8 : LN_W16;
      plan.err  = (offset[1:0] != 2'b00) ||
                  (xfer_size_e'(size) == SZ_WORD) || (xfer_size_e'(size) == SZ_BAD);
    end else begin
      case (xfer_size_e'(size))
        SZ_BYTE: begin
          addr      = base2 | ADDR_W'(offset[0]);
          plan.bhe  = offset[0];
          plan.lane = offset[0] ? LN_HI8 : LN_LO8;
        end
        SZ_HALF: begin
          plan.bhe  = 1'b1;
          plan.lane = LN_W16;
          plan.err  = offset[0];
        end
        SZ_WORD: begin
          if (offset[2]) begin
            addr      = base2 | ADDR_W'(1);
            plan.lane = LN_LO8;
          end else begin
            plan.bhe   = 1'b1;
            plan.lane  = LN_W16;
            plan.split = 1'b1;
            plan.err   = wr;
          end
          plan.err = plan.err | offset[0];
        end
        default: plan.err = 1'b1;
      endcase
      plan.err = plan.err | offset[1];
    end
  end
endmodule

// File: rtl/isa_cycle_seq.sv
module isa_cycle_seq
  import isa_bridge_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int STB_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [15:0]       req_wdata,
  input  isa_plan_t         plan,
  input  logic [ADDR_W-1:0] plan_addr,
  input  logic [15:0]       isa_din,
  output logic              req_ready,
  output logic              rsp_err,
  output logic              isa_ior,
  output logic              isa_iow,
  output logic              isa_bhe,
  output logic [ADDR_W-1:0] isa_addr,
  output lane_e             lane_q,
  output logic              split_q,
  output logic              wr_q,
  output logic [15:0]       wd_q,
  output logic [15:0]       half0_q,
  output logic [15:0]       half1_q
);
  localparam int CW = (STB_CLKS > 1) ? $clog2(STB_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STB_CLKS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_STRB, ST_GAP, ST_RESP} seq_st_e;

  seq_st_e           st;
  logic [CW-1:0]     cnt;
  logic              second_q, err_q, bhe_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; second_q <= 1'b0; err_q <= 1'b0; bhe_q <= 1'b0;
      addr_q <= '0; lane_q <= LN_LO8; split_q <= 1'b0; wr_q <= 1'b0; wd_q <= '0;
      half0_q <= '0; half1_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          addr_q   <= plan_addr;
          bhe_q    <= plan.bhe;
          lane_q   <= plan.lane;
          split_q  <= plan.split;
          err_q    <= plan.err;
          wr_q     <= req_write;
          wd_q     <= req_wdata;
          second_q <= 1'b0;
          cnt      <= '0;
          st       <= plan.err ? ST_RESP : ST_STRB;
        end
        ST_STRB: begin
          if (cnt == LAST) begin
            cnt <= '0;
            if (second_q) half1_q <= isa_din;
            else          half0_q <= isa_din;
            if (split_q && !second_q) begin
              st       <= ST_GAP;
              second_q <= 1'b1;
              addr_q   <= addr_q + ADDR_W'(2);
            end else begin
              st <= ST_RESP;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_GAP:  st <= ST_STRB;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_RESP);
  assign rsp_err   = req_ready & err_q;
  assign isa_ior   = (st == ST_STRB) & ~wr_q;
  assign isa_iow   = (st == ST_STRB) & wr_q;
  assign isa_bhe   = (st == ST_STRB) & bhe_q;
  assign isa_addr  = addr_q;

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(isa_ior && isa_iow));
  // R10
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($rose(isa_ior) || $rose(isa_iow)) && (STB_CLKS > 1)) |=> (isa_ior || isa_iow));
  // R2
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
  // R9
  err_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && req_valid && plan.err) |=> (req_ready && rsp_err && !isa_ior && !isa_iow));
  // R8
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP) |=> (isa_ior && !req_ready));
endmodule

// File: rtl/isa_lane_steer.sv
module isa_lane_steer
  import isa_bridge_pkg::*;
(
  input  lane_e       lane,
  input  logic        split,
  input  logic        wr,
  input  logic        err,
  input  logic [15:0] half0,
  input  logic [15:0] half1,
  input  logic [15:0] wd,
  output logic [31:0] rdata,
  output logic [15:0] dout
);
  always_comb begin
    rdata = '0;
    if (!err && !wr) begin
      case (lane)
        LN_LO8:  rdata = {24'h0, half0[7:0]};
        LN_HI8:  rdata = {24'h0, half0[15:8]};
        default: rdata = split ? {half1, half0} : {16'h0, half0};
      endcase
    end
  end

  always_comb begin
    case (lane)
      LN_LO8:  dout = {8'h00, wd[7:0]};
      LN_HI8:  dout = {wd[7:0], 8'h00};
      default: dout = wd;
    endcase
  end
endmodule

// File: rtl/isa_io_bridge.sv
module isa_io_bridge
  import isa_bridge_pkg::*;
#(
  parameter int OFS_W    = 12,
  parameter int STB_CLKS = 2,
  localparam int ADDR_W  = OFS_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [15:0]       req_wdata,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic [ADDR_W-1:0] isa_addr,
  output logic              isa_bhe,
  output logic              isa_ior,
  output logic              isa_iow,
  output logic [15:0]       isa_dout,
  input  logic [15:0]       isa_din
);
  isa_plan_t         plan;
  logic [ADDR_W-1:0] plan_addr;
  lane_e             lane_q;
  logic              split_q, wr_q;
  logic [15:0]       wd_q, half0_q, half1_q, dout_s;
  logic [31:0]       rdata_s;

  isa_addr_decode #(.OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_dec (
    .offset(req_offset), .size(req_size), .wr(req_write),
    .plan(plan), .addr(plan_addr)
  );

  isa_cycle_seq #(.ADDR_W(ADDR_W), .STB_CLKS(STB_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wdata(req_wdata), .plan(plan), .plan_addr(plan_addr), .isa_din(isa_din),
    .req_ready(req_ready), .rsp_err(rsp_err), .isa_ior(isa_ior), .isa_iow(isa_iow),
    .isa_bhe(isa_bhe), .isa_addr(isa_addr), .lane_q(lane_q), .split_q(split_q),
    .wr_q(wr_q), .wd_q(wd_q), .half0_q(half0_q), .half1_q(half1_q)
  );

  isa_lane_steer u_steer (
    .lane(lane_q), .split(split_q), .wr(wr_q), .err(rsp_err),
    .half0(half0_q), .half1(half1_q), .wd(wd_q), .rdata(rdata_s), .dout(dout_s)
  );

  assign isa_dout  = isa_iow ? dout_s : 16'h0;
  assign rsp_rdata = req_ready ? rdata_s : 32'h0;

  // R10
  dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !isa_iow |-> (isa_dout == 16'h0));
endmodule

// File: tb/sim_isa_io_bridge.sv
`timescale 1ns/1ps
module sim_isa_io_bridge;
  localparam int S = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_offset = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        rsp_err;
  logic [31:0] rsp_rdata;
  logic [10:0] isa_addr;
  logic        isa_bhe, isa_ior, isa_iow;
  logic [15:0] isa_dout, isa_din;

  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  function automatic logic [15:0] pdata(int a);
    logic [7:0] lo, hi;
    lo = 8'((a % 256) ^ 'h5A);
    hi = 8'(((a / 256) * 32 + (a % 32)) ^ 'h93);
    return {hi, lo};
  endfunction

  assign isa_din = pdata(int'(isa_addr));

  isa_io_bridge #(.OFS_W(12), .STB_CLKS(S)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_offset(req_offset), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .isa_addr(isa_addr), .isa_bhe(isa_bhe), .isa_ior(isa_ior), .isa_iow(isa_iow),
    .isa_dout(isa_dout), .isa_din(isa_din)
  );

  // bus monitor, sampled on falling edges
  int cyc = 0, nseg = 0, stb_cnt = 0, first_stb = 0, last_stb = 0, both_hi = 0;
  bit prev_stb = 1'b0;
  int seg_addr[2];
  bit seg_bhe[2], seg_wr[2];
  logic [15:0] seg_dout[2];

  always @(negedge clk) begin
    cyc++;
    if (isa_ior || isa_iow) begin
      stb_cnt++;
      last_stb = cyc;
      if (isa_ior && isa_iow) both_hi++;
      if (!prev_stb) begin
        if (nseg == 0) first_stb = cyc;
        if (nseg < 2) begin
          seg_addr[nseg] = int'(isa_addr);
          seg_bhe[nseg]  = isa_bhe;
          seg_wr[nseg]   = isa_iow;
          seg_dout[nseg] = isa_dout;
        end
        nseg++;
      end
    end
    prev_stb = isa_ior || isa_iow;
  end

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic run_txn(int off, int sz, bit wr);
    bit e_err, trick, split;
    int e_nseg, a0, a1, lane, lat, e_lat, span, grp, q;
    bit e_bhe;
    logic [31:0] e_rd, got_rd;
    logic [15:0] wd, e_dout;
    bit got_err;
    string tag;

    wd = 16'(((off % 256) ^ 'hC3) * 256 + (off / 16));
    grp = off / 32;
    q = off / 4;
    e_err = 0; split = 0; trick = 0; e_bhe = 0; lane = 0; a0 = 0; a1 = 0; tag = "R4";
    if (grp == 'h7F || grp == 'h6F || grp == 'h5F) begin
      tag = "R3"; a0 = q; lane = (sz == 0) ? 0 : 2;
      e_err = (off % 4 != 0) || sz >= 2;
    end else begin
      e_err = ((off / 2) % 2 == 1);
      if (sz == 0) begin
        a0 = q * 2 + off % 2; e_bhe = (off % 2 == 1); lane = e_bhe ? 1 : 0;
        tag = e_bhe ? "R5" : "R4";
      end else if (sz == 1) begin
        tag = "R6"; a0 = q * 2; e_bhe = 1; lane = 2; e_err = e_err || (off % 2 == 1);
      end else if (sz == 2) begin
        e_err = e_err || (off % 2 == 1);
        if ((off / 4) % 2 == 1) begin
          tag = "R7"; trick = 1; a0 = q * 2 + 1; lane = 0;
        end else begin
          tag = "R8"; split = 1; a0 = q * 2; a1 = q * 2 + 2; e_bhe = 1; lane = 2;
          e_err = e_err || wr;
        end
      end else begin
        e_err = 1;
      end
    end
    if (e_err) begin tag = "R9"; split = 0; end
    e_nseg = e_err ? 0 : (split ? 2 : 1);
    e_lat  = e_err ? 1 : (split ? 2 * S + 2 : S + 1);
    if (e_err || wr) e_rd = 0;
    else if (lane == 0) e_rd = {24'h0, pdata(a0)[7:0]};
    else if (lane == 1) e_rd = {24'h0, pdata(a0)[15:8]};
    else if (split) e_rd = {pdata(a1), pdata(a0)};
    else e_rd = {16'h0, pdata(a0)};
    e_dout = (lane == 0) ? {8'h00, wd[7:0]} : (lane == 1) ? {wd[7:0], 8'h00} : wd;

    @(negedge clk);
    nseg = 0; stb_cnt = 0; both_hi = 0;
    req_offset = 12'(off); req_size = 2'(sz); req_write = wr; req_wdata = wd;
    req_valid = 1'b1;
    lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
    end while (!req_ready && lat < 60);
    got_err = rsp_err; got_rd = rsp_rdata;
    req_valid = 1'b0;
    span = (nseg > 0) ? last_stb - first_stb + 1 : 0;

    chk(lat == e_lat, "R2", $sformatf("latency off=%0h sz=%0d wr=%0d", off, sz, wr), lat, e_lat);
    chk(got_err == e_err, tag, $sformatf("error flag off=%0h sz=%0d wr=%0d", off, sz, wr), got_err, e_err);
    chk(stb_cnt == e_nseg * S && both_hi == 0, "R10", $sformatf("strobe clocks off=%0h", off), stb_cnt, e_nseg * S);
    chk(nseg == e_nseg, tag, $sformatf("cycle count off=%0h", off), nseg, e_nseg);
    chk(got_rd == e_rd, tag, $sformatf("read data off=%0h sz=%0d wr=%0d", off, sz, wr), got_rd, e_rd);
    if (e_nseg > 0 && nseg > 0) begin
      chk(seg_addr[0] == a0, tag, $sformatf("address off=%0h sz=%0d", off, sz), seg_addr[0], a0);
      chk(seg_bhe[0] == e_bhe, tag, $sformatf("byte-high enable off=%0h sz=%0d", off, sz), seg_bhe[0], e_bhe);
      chk(seg_wr[0] == wr, "R10", $sformatf("strobe kind off=%0h", off), seg_wr[0], wr);
      chk(span == (split ? 2 * S + 1 : S), split ? "R8" : "R10", $sformatf("strobe span off=%0h", off),
          span, split ? 2 * S + 1 : S);
      if (wr) chk(seg_dout[0] == e_dout, tag, $sformatf("bus write data off=%0h sz=%0d", off, sz), seg_dout[0], e_dout);
    end
    if (split && nseg == 2)
      chk(seg_addr[1] == a1 && seg_bhe[1], "R8", $sformatf("second address off=%0h", off), seg_addr[1], a1);
    @(negedge clk);
    chk(!req_ready, "R2", "ready held past one clock", req_ready, 0);
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!req_ready && !rsp_err && !isa_ior && !isa_iow && !isa_bhe, "R1", "outputs in reset",
        {req_ready, rsp_err, isa_ior, isa_iow, isa_bhe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_ready && !rsp_err && !isa_ior && !isa_iow && !isa_bhe, "R1", "outputs after reset",
        {req_ready, rsp_err, isa_ior, isa_iow, isa_bhe}, 0);
    for (int off = 0; off < 4096; off++)
      for (int sz = 0; sz < 3; sz++)
        run_txn(off, sz, 1'b0);
    for (int off = 0; off < 4096; off++) begin
      run_txn(off, 0, 1'b1);
      run_txn(off, 1, 1'b1);
      if (off % 4 == 0) run_txn(off, 2, 1'b1);
    end
    run_txn('h000, 3, 1'b0);
    run_txn('hFE0, 3, 1'b0);
    run_txn('h440, 3, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule